// File: doc/BRIEF.md
# Multiply-High-Word Execution Unit

This block is a combinational execution unit. It takes two 64-bit register operands and an operation record. It returns the upper 32 bits of the 64-bit product of the low 32-bit words of the operands. A flag in the operation record chooses between an unsigned multiply and a two's-complement multiply, and both forms share one operation code. The 32-bit high word is copied into both halves of the 64-bit result.

Signed operation works on magnitudes. Each operand whose bit 31 is set is negated into a 32-bit unsigned magnitude, and the two magnitudes are multiplied. The product is negated when exactly one operand was negative. The unit raises its result-valid flag in the same cycle whenever the operation code selects it. It forwards the summary-overflow status bit untouched and reports its carry outputs as not written.

Top module: `mulh_unit`

## Requirements
- R1: With `opSigned` low and `opCode` equal to the unit's code (default 7'h2A), the high word is bits 63:32 of the unsigned product of `opA[31:0]` and `opB[31:0]`.
- R2: Bits 63:32 of `opA` and `opB` have no effect on `resData` in either mode.
- R3: While `resValid` is high, `resData[63:32]` and `resData[31:0]` both hold the same high product word.
- R4: With `opSigned` high, the high word is bits 63:32 of the 64-bit two's-complement product of the low operand words, each read as a signed 32-bit value.
- R5: An operand of 32'h80000000 in signed mode is handled as magnitude 2^31. For example, 32'h80000000 times itself gives 32'h40000000, and 32'h80000000 times 1 gives 32'hFFFFFFFF.
- R6: `soOut` equals `soIn` at all times, whatever the opcode and operands.
- R7: `resValid` is high exactly when `opCode` equals the unit's code, in the same cycle and with no register in the path.
- R8: `caWritten` is always low and `caOut` is always 2'b00.
- R9: In signed mode, a zero operand gives a zero result even when the operand signs differ.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 64 | First register operand; only bits 31:0 are used |
| opB | input | 64 | Second register operand; only bits 31:0 are used |
| opCode | input | 7 | Operation code from the operation record |
| opSigned | input | 1 | 1 selects the signed multiply, 0 the unsigned one |
| soIn | input | 1 | Summary-overflow status input |
| resData | output | 64 | High product word, replicated into both halves |
| resValid | output | 1 | High when the opcode selects this unit |
| soOut | output | 1 | Summary-overflow status, forwarded from soIn |
| caOut | output | 2 | Carry outputs, held at zero |
| caWritten | output | 1 | Carry write flag, always low |

## Verification
The unsigned form is driven with small operands, all-ones operands and a carry into bit 32. These cases separate a correct high-word select from an off-by-one slice or a truncated product. The signed form is driven with every mix of operand signs and with the most negative value against itself, against +1 and against the largest positive value. These cases catch a missing conditional negation, a wrong sign rule and a magnitude that overflows. Garbage in the upper operand halves, including a set bit 63, shows whether upper bits leak in or decide the sign. A mismatched opcode and both levels of the status input show that the valid decode and the status passthrough are independent of the datapath.

// File: rtl/mulh_pkg.sv
package mulh_pkg;

  // Strobes sent from the decode control to the datapath
  typedef struct packed {
    logic active;      // opcode selects this unit
    logic signedMode;  // two's-complement variant requested
  } mulh_strobe_t;

endpackage

// File: rtl/mulh_mag.sv
// Converts one operand word into an unsigned magnitude plus a sign flag.
module mulh_mag #(
  parameter int HALF = 32
) (
  input  logic [HALF-1:0] word,
  input  logic            useSign,
  output logic [HALF-1:0] mag,
  output logic            neg
);

  always_comb begin
    neg = useSign & word[HALF-1];
    // The HALF-bit result of negating the most negative value is itself,
    // and read as unsigned that is exactly 2^(HALF-1).
    if (neg) mag = ~word + HALF'(1);
    else     mag = word;
  end

endmodule

// File: rtl/mulh_ctrl.sv
// Decodes the operation record into datapath strobes and status outputs.
module mulh_ctrl
  import mulh_pkg::*;
#(
  parameter int          OP_W      = 7,
  parameter int          CA_W      = 2,
  parameter logic [OP_W-1:0] MULH_CODE = 7'h2A
) (
  input  logic [OP_W-1:0] opCode,
  input  logic            opSigned,
  input  logic            soIn,
  output mulh_strobe_t    strobes,
  output logic            resValid,
  output logic            soOut,
  output logic [CA_W-1:0] caOut,
  output logic            caWritten
);

  always_comb begin
    strobes.active     = (opCode == MULH_CODE);
    strobes.signedMode = opSigned;
    resValid           = strobes.active;
    soOut              = soIn;
    caOut              = '0;
    caWritten          = 1'b0;
  end

endmodule

// File: rtl/mulh_datapath.sv
// Magnitude conversion, unsigned multiply, conditional negation, replication.
module mulh_datapath
  import mulh_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int HALF = 32
) (
  input  logic [XLEN-1:0] opA,
  input  logic [XLEN-1:0] opB,
  input  mulh_strobe_t    strobes,
  output logic [XLEN-1:0] resData
);

  localparam int PROD_W = 2 * HALF;
  localparam int REPL   = XLEN / HALF;

  logic [HALF-1:0] lowWord [2];
  logic [HALF-1:0] magWord [2];
  logic            negFlag [2];

  logic [PROD_W-1:0] magProd;
  logic [PROD_W-1:0] sgnProd;
  logic              flipSign;
  logic [HALF-1:0]   hiWord;

  // Upper operand halves do not take part in the operation.
  logic unusedUpper;
  assign unusedUpper = ^{opA[XLEN-1:HALF], opB[XLEN-1:HALF]};

  assign lowWord[0] = opA[HALF-1:0];
  assign lowWord[1] = opB[HALF-1:0];

  for (genvar k = 0; k < 2; k++) begin : g_mag
    mulh_mag #(.HALF(HALF)) u_mag (
      .word   (lowWord[k]),
      .useSign(strobes.signedMode),
      .mag    (magWord[k]),
      .neg    (negFlag[k])
    );
  end

  always_comb begin
    magProd  = PROD_W'(magWord[0]) * PROD_W'(magWord[1]);
    flipSign = negFlag[0] ^ negFlag[1];
    sgnProd  = flipSign ? (~magProd + PROD_W'(1)) : magProd;
    hiWord   = strobes.active ? sgnProd[PROD_W-1:HALF] : '0;
  end

  for (genvar r = 0; r < REPL; r++) begin : g_repl
    assign resData[r*HALF +: HALF] = hiWord;
  end

endmodule

// File: rtl/mulh_unit.sv
// Top level: thin wrapper joining control and datapath.
module mulh_unit
  import mulh_pkg::*;
#(
  parameter int              XLEN      = 64,
  parameter int              HALF      = 32,
  parameter int              OP_W      = 7,
  parameter int              CA_W      = 2,
  parameter logic [OP_W-1:0] MULH_CODE = 7'h2A
) (
  input  logic [XLEN-1:0] opA,
  input  logic [XLEN-1:0] opB,
  input  logic [OP_W-1:0] opCode,
  input  logic            opSigned,
  input  logic            soIn,
  output logic [XLEN-1:0] resData,
  output logic            resValid,
  output logic            soOut,
  output logic [CA_W-1:0] caOut,
  output logic            caWritten
);

  mulh_strobe_t strobes;

  mulh_ctrl #(
    .OP_W(OP_W), .CA_W(CA_W), .MULH_CODE(MULH_CODE)
  ) u_ctrl (
    .opCode   (opCode),
    .opSigned (opSigned),
    .soIn     (soIn),
    .strobes  (strobes),
    .resValid (resValid),
    .soOut    (soOut),
    .caOut    (caOut),
    .caWritten(caWritten)
  );

  mulh_datapath #(
    .XLEN(XLEN), .HALF(HALF)
  ) u_dp (
    .opA    (opA),
    .opB    (opB),
    .strobes(strobes),
    .resData(resData)
  );

endmodule

// File: rtl/mulh_unit_chk.sv
// Checker bound to mulh_unit; reference products use signed arithmetic.
module mulh_unit_chk #(
  parameter int              XLEN      = 64,
  parameter int              HALF      = 32,
  parameter int              OP_W      = 7,
  parameter int              CA_W      = 2,
  parameter logic [OP_W-1:0] MULH_CODE = 7'h2A
) (
  input logic [XLEN-1:0] opA,
  input logic [XLEN-1:0] opB,
  input logic [OP_W-1:0] opCode,
  input logic            opSigned,
  input logic            soIn,
  input logic [XLEN-1:0] resData,
  input logic            resValid,
  input logic            soOut,
  input logic [CA_W-1:0] caOut,
  input logic            caWritten
);

  localparam int PROD_W = 2 * HALF;

  logic [PROD_W-1:0]        uRef;
  logic signed [PROD_W-1:0] sRef;

  always_comb begin
    uRef = PROD_W'(opA[HALF-1:0]) * PROD_W'(opB[HALF-1:0]);
    sRef = PROD_W'($signed(opA[HALF-1:0])) * PROD_W'($signed(opB[HALF-1:0]));

    p_valid_decode_r7: assert (resValid == (opCode == MULH_CODE))
      else $error("R7 resValid mismatch");
    p_so_forward_r6: assert (soOut == soIn)
      else $error("R6 status not forwarded");
    p_no_carry_r8: assert (!caWritten && caOut == '0)
      else $error("R8 carry written");
    if (resValid) begin
      p_halves_equal_r3: assert (resData[XLEN-1:HALF] == resData[HALF-1:0])
        else $error("R3 halves differ");
      if (!opSigned) begin
        p_unsigned_hi_r1: assert (resData[HALF-1:0] == uRef[PROD_W-1:HALF])
          else $error("R1 unsigned high word wrong");
      end else begin
        p_signed_hi_r4: assert (resData[HALF-1:0] == sRef[PROD_W-1:HALF])
          else $error("R4 signed high word wrong");
      end
    end
  end

endmodule

bind mulh_unit mulh_unit_chk #(
  .XLEN(XLEN), .HALF(HALF), .OP_W(OP_W), .CA_W(CA_W), .MULH_CODE(MULH_CODE)
) u_chk (
  .opA(opA), .opB(opB), .opCode(opCode), .opSigned(opSigned), .soIn(soIn),
  .resData(resData), .resValid(resValid), .soOut(soOut),
  .caOut(caOut), .caWritten(caWritten)
);

// File: tb/sim_mulh_unit.sv
module sim_mulh_unit;

  localparam logic [6:0] CODE = 7'h2A;

  typedef struct packed {
    logic        sgn;
    logic [63:0] a;
    logic [63:0] b;
    logic [31:0] hi;
  } vec_t;

  localparam int NVEC = 13;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 64'h3,                  64'h5,                  32'h0},
    '{1'b0, 64'hFFFFFFFF,           64'hFFFFFFFF,           32'hFFFFFFFE},
    '{1'b0, 64'h80000000,           64'h2,                  32'h1},
    '{1'b0, 64'hDEADBEEF_00010000,  64'h12345678_00010000,  32'h1},
    '{1'b1, 64'hFFFFFFFF,           64'h1,                  32'hFFFFFFFF},
    '{1'b1, 64'hFFFFFFFF,           64'hFFFFFFFF,           32'h0},
    '{1'b1, 64'h80000000,           64'h80000000,           32'h40000000},
    '{1'b1, 64'h80000000,           64'h1,                  32'hFFFFFFFF},
    '{1'b1, 64'h80000000,           64'h7FFFFFFF,           32'hC0000000},
    '{1'b1, 64'h0,                  64'hFFFFFFFB,           32'h0},
    '{1'b1, 64'hFFFFFFFE,           64'h40000000,           32'hFFFFFFFF},
    '{1'b0, 64'hFFFFFFFF,           64'h1,                  32'h0},
    '{1'b1, 64'hFFFFFFFF_00000002,  64'h3,                  32'h0}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] opA = '0;
  logic [63:0] opB = '0;
  logic [6:0]  opCode = '0;
  logic        opSigned = 1'b0;
  logic        soIn = 1'b0;
  logic [63:0] resData;
  logic        resValid;
  logic        soOut;
  logic [1:0]  caOut;
  logic        caWritten;

  int  nRun = 0;
  int  nFail = 0;
  bit  finished = 0;

  always #5 clk = ~clk;

  mulh_unit u0 (
    .opA(opA), .opB(opB), .opCode(opCode), .opSigned(opSigned), .soIn(soIn),
    .resData(resData), .resValid(resValid), .soOut(soOut),
    .caOut(caOut), .caWritten(caWritten)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [63:0] a, input logic [63:0] b,
                       input logic [6:0] code, input logic sgn, input logic so);
    @(posedge clk);
    opA = a; opB = b; opCode = code; opSigned = sgn; soIn = so;
    @(negedge clk);
  endtask

  function automatic logic [31:0] refHi(input logic [63:0] a, input logic [63:0] b, input logic sgn);
    logic signed [63:0] sp;
    logic [63:0] up;
    up = 64'(a[31:0]) * 64'(b[31:0]);
    sp = 64'($signed(a[31:0])) * 64'($signed(b[31:0]));
    return sgn ? sp[63:32] : up[63:32];
  endfunction

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    nRun++; nFail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // Idle state: no opcode selected
    check("R7 idle valid", 64'(resValid), 64'h0);
    check("R8 idle carry", 64'({caWritten, caOut}), 64'h0);

    // Table walk: R1 unsigned, R4 signed, R3 replication, R2/R5/R9 rows
    for (int i = 0; i < NVEC; i++) begin
      drive(VECS[i].a, VECS[i].b, CODE, VECS[i].sgn, 1'b0);
      check(VECS[i].sgn ? "R4 table" : "R1 table", resData,
            {VECS[i].hi, VECS[i].hi});
      check("R3 table ref", resData,
            {refHi(VECS[i].a, VECS[i].b, VECS[i].sgn), refHi(VECS[i].a, VECS[i].b, VECS[i].sgn)});
      check("R7 table valid", 64'(resValid), 64'h1);
    end

    // R2: upper bits differ, result same as clean operands
    drive(64'hFFFFFFFF_00000007, 64'h80000000_00000009, CODE, 1'b1, 1'b0);
    check("R2 signed upper ignored", resData, 64'h0);
    drive(64'h7FFFFFFF_FFFFFFFF, 64'hFFFFFFFF_00000002, CODE, 1'b0, 1'b0);
    check("R2 unsigned upper ignored", resData, 64'h00000001_00000001);

    // R5: most negative times itself and times +1
    drive(64'h80000000, 64'h80000000, CODE, 1'b1, 1'b0);
    check("R5 min*min", resData, 64'h40000000_40000000);
    drive(64'h1, 64'h80000000, CODE, 1'b1, 1'b0);
    check("R5 1*min", resData, 64'hFFFFFFFF_FFFFFFFF);

    // R9: zero with negative partner
    drive(64'hFFFFFFFF, 64'h0, CODE, 1'b1, 1'b0);
    check("R9 neg*zero", resData, 64'h0);

    // R6: status forwarded in both levels, with and without opcode match
    drive(64'h5, 64'h6, CODE, 1'b0, 1'b1);
    check("R6 so high match", 64'(soOut), 64'h1);
    drive(64'h5, 64'h6, 7'h11, 1'b0, 1'b1);
    check("R6 so high other op", 64'(soOut), 64'h1);
    drive(64'h5, 64'h6, 7'h11, 1'b1, 1'b0);
    check("R6 so low other op", 64'(soOut), 64'h0);

    // R7: mismatching opcodes
    drive(64'h5, 64'h6, 7'h2B, 1'b0, 1'b0);
    check("R7 near code", 64'(resValid), 64'h0);
    drive(64'h5, 64'h6, 7'h00, 1'b1, 1'b0);
    check("R7 zero code", 64'(resValid), 64'h0);

    // R8: carry not written during an active operation
    drive(64'hFFFFFFFF, 64'hFFFFFFFF, CODE, 1'b0, 1'b1);
    check("R8 carry active", 64'({caWritten, caOut}), 64'h0);

    summary();
  end

endmodule